// File: doc/BRIEF.md
# Two-Level Page Walker with Large-Page High Addressing

This block resolves a 32-bit linear address into a physical address by walking a two-level page hierarchy held in memory. A single-cycle `start` pulse latches the linear address, the directory base, the large-page enable, the high-address mode select, the configured physical-address width and the access direction. The walker then reads the directory entry over a request/acknowledge memory port and, when that entry points at a page table, reads the table entry as well. It finishes with a one-cycle `done` pulse carrying either a physical address of up to 40 bits or a fault code.

When large pages are enabled, a directory entry with its size bit set maps a whole 4 MB page. Spare bits of that entry supply physical address bits above bit 31, so only 4 MB pages can reach memory above 4 GB. Pages of 4 KB always land below 4 GB. The walker keeps the accessed and dirty flags current by writing an entry back, and only when a flag really changes. No write-back happens on a walk that faults.

Top module: `page_walker`

## Requirements
- R1: After reset `mem_req`, `done` and `busy` are low.
- R2: The directory entry is read at `dir_base + lin_addr[31:22]*4`. The table entry is read at `{pde[31:12],12'h000} + lin_addr[21:12]*4`.
- R3: When `large_en`=1 and directory entry bit 7 is 1, the entry maps a 4 MB page: `phys_addr` = {high bits, pde[31:22], lin_addr[21:0]}. When `large_en`=0, bit 7 is ignored and the entry is used as a table pointer.
- R4: With `wide_mode`=0, pde[16:13] gives physical bits 35..32 and bits 39..36 are zero. A large entry with any of pde[21:17] set ends with fault code 3.
- R5: With `wide_mode`=1, pde[20:13] gives physical bits 39..32. A large entry with pde[21] set ends with fault code 3.
- R6: A large-page high bit that lands at physical position `phys_width` or above ends the walk with fault code 3. A high bit below `phys_width` is accepted.
- R7: A 4 KB page gives `phys_addr` = {8'h00, pte[31:12], lin_addr[11:0]}.
- R8: A directory entry with bit 0 clear gives fault code 1. A table entry with bit 0 clear gives fault code 2. No memory write is issued on any faulting walk.
- R9: A successful walk sets bit 5 (accessed) in every entry it used. On `is_write`=1 it also sets bit 6 (dirty) in the entry that maps the page. An entry is written back, with only those bits changed, only when its value changes. The directory write comes before the table write.
- R10: A memory request holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until the cycle in which `mem_ack` is high. Only one request is outstanding at a time.
- R11: `done` is high for exactly one cycle, with `fault_code` 0 on success. A `start` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (accepted only when idle) |
| lin_addr | input | 32 | Linear address to translate |
| dir_base | input | 32 | Physical base of the page directory |
| large_en | input | 1 | Enables 4 MB pages |
| wide_mode | input | 1 | 0: 36-bit high field, 1: 40-bit high field |
| phys_width | input | 6 | Configured maximum physical address width (32..40) |
| is_write | input | 1 | Access is a write |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault_code | output | 2 | 0 ok, 1 directory absent, 2 table absent, 3 reserved bit |
| phys_addr | output | 40 | Translated physical address |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Entry address |
| mem_wdata | output | 32 | Write-back entry value |
| mem_ack | input | 1 | Request completes this cycle |
| mem_rdata | input | 32 | Entry read data, valid with `mem_ack` |

## Verification
The hardest case to reach from the ports is a walk whose directory entry still has its accessed flag clear but whose table entry is absent. The walker has already read a directory entry that would need a write, yet it must issue none. The bench builds exactly that table, and it also replays one entry under both high-address modes and under two widths, so that the same bits flip between reserved and address. A second `start` is pulsed while a walk is in flight, and the memory responder varies its acknowledge delay per request, so the request-holding rule and the in-order write-back are seen under stalls.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int P_BIT  = 0;
  localparam int A_BIT  = 5;
  localparam int D_BIT  = 6;
  localparam int PS_BIT = 7;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_DIR, S_CHK_DIR, S_RD_TBL, S_CHK_TBL, S_WB_DIR, S_WB_TBL, S_FIN
  } walk_state_t;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0, FLT_DIR_ABSENT = 2'd1, FLT_TBL_ABSENT = 2'd2, FLT_RSVD = 2'd3
  } flt_t;

  function automatic logic [31:0] dir_entry_addr(input logic [31:0] base,
                                                 input logic [9:0] idx);
    return base + {20'd0, idx, 2'b00};
  endfunction

  function automatic logic [31:0] tbl_entry_addr(input logic [19:0] tframe,
                                                 input logic [9:0] idx);
    return {tframe, 12'd0} + {20'd0, idx, 2'b00};
  endfunction
endpackage

// File: rtl/pw_flag_merge.sv
module pw_flag_merge (
  input  logic [31:0] entry,
  input  logic        mark_dirty,
  output logic [31:0] merged,
  output logic        changed
);
  import pw_pkg::*;
  always_comb begin
    merged = entry;
    merged[A_BIT] = 1'b1;
    if (mark_dirty) merged[D_BIT] = 1'b1;
    changed = (merged != entry);
  end
endmodule

// File: rtl/pw_large_map.sv
module pw_large_map #(
  parameter int PA_W = 40
) (
  input  logic [31:0]     pde,
  input  logic [21:0]     offs,
  input  logic            wide,
  input  logic [5:0]      width,
  output logic [PA_W-1:0] pa,
  output logic            rsvd_bad
);
  localparam int HI_W = PA_W - 32;
  localparam logic [31:0] RSV_NARROW = 32'h003E_0000;
  localparam logic [31:0] RSV_WIDE   = (32'd1 << 22) - (32'd1 << (13 + HI_W));

  logic [HI_W-1:0] hi;
  logic [HI_W-1:0] over;

  always_comb begin
    if (wide) hi = pde[13 +: HI_W];
    else      hi = {{(HI_W-4){1'b0}}, pde[16:13]};
  end

  for (genvar i = 0; i < HI_W; i++) begin : g_over
    assign over[i] = hi[i] && (6'(32 + i) >= width);
  end

  assign rsvd_bad = (|(pde & (wide ? RSV_WIDE : RSV_NARROW))) || (|over);
  assign pa = {hi, pde[31:22], offs};
endmodule

// File: rtl/page_walker.sv
module page_walker #(
  parameter int PA_W = 40
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [31:0]     lin_addr,
  input  logic [31:0]     dir_base,
  input  logic            large_en,
  input  logic            wide_mode,
  input  logic [5:0]      phys_width,
  input  logic            is_write,
  output logic            busy,
  output logic            done,
  output logic [1:0]      fault_code,
  output logic [PA_W-1:0] phys_addr,
  output logic            mem_req,
  output logic            mem_we,
  output logic [31:0]     mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic            mem_ack,
  input  logic [31:0]     mem_rdata
);
  import pw_pkg::*;

  walk_state_t     state;
  flt_t            fault_q;
  logic [31:0]     lin_q, base_q, pde_q, pte_q;
  logic            large_q, wide_q, wr_q;
  logic [5:0]      width_q;
  logic [PA_W-1:0] pa_q;

  // named internal events
  logic            dir_is_large, large_rsvd, dir_chg, tbl_chg;
  logic [31:0]     dir_new, tbl_new, wb_orig;
  logic [PA_W-1:0] large_pa, small_pa;

  assign dir_is_large = large_q && pde_q[PS_BIT];
  assign small_pa     = {{(PA_W-32){1'b0}}, pte_q[31:12], lin_q[11:0]};

  pw_large_map #(.PA_W(PA_W)) u_large (
    .pde(pde_q), .offs(lin_q[21:0]), .wide(wide_q), .width(width_q),
    .pa(large_pa), .rsvd_bad(large_rsvd)
  );

  pw_flag_merge u_dir_merge (
    .entry(pde_q), .mark_dirty(wr_q && dir_is_large),
    .merged(dir_new), .changed(dir_chg)
  );

  pw_flag_merge u_tbl_merge (
    .entry(pte_q), .mark_dirty(wr_q),
    .merged(tbl_new), .changed(tbl_chg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      fault_q <= FLT_NONE;
      lin_q   <= '0;
      base_q  <= '0;
      pde_q   <= '0;
      pte_q   <= '0;
      large_q <= 1'b0;
      wide_q  <= 1'b0;
      wr_q    <= 1'b0;
      width_q <= '0;
      pa_q    <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          lin_q   <= lin_addr;
          base_q  <= dir_base;
          large_q <= large_en;
          wide_q  <= wide_mode;
          width_q <= phys_width;
          wr_q    <= is_write;
          fault_q <= FLT_NONE;
          pa_q    <= '0;
          state   <= S_RD_DIR;
        end
        S_RD_DIR: if (mem_ack) begin
          pde_q <= mem_rdata;
          state <= S_CHK_DIR;
        end
        S_CHK_DIR: begin
          if (!pde_q[P_BIT]) begin
            fault_q <= FLT_DIR_ABSENT;
            state   <= S_FIN;
          end else if (dir_is_large) begin
            if (large_rsvd) begin
              fault_q <= FLT_RSVD;
              state   <= S_FIN;
            end else begin
              pa_q  <= large_pa;
              state <= dir_chg ? S_WB_DIR : S_FIN;
            end
          end else begin
            state <= S_RD_TBL;
          end
        end
        S_RD_TBL: if (mem_ack) begin
          pte_q <= mem_rdata;
          state <= S_CHK_TBL;
        end
        S_CHK_TBL: begin
          if (!pte_q[P_BIT]) begin
            fault_q <= FLT_TBL_ABSENT;
            state   <= S_FIN;
          end else begin
            pa_q <= small_pa;
            if (dir_chg)      state <= S_WB_DIR;
            else if (tbl_chg) state <= S_WB_TBL;
            else              state <= S_FIN;
          end
        end
        S_WB_DIR: if (mem_ack)
          state <= (!dir_is_large && tbl_chg) ? S_WB_TBL : S_FIN;
        S_WB_TBL: if (mem_ack) state <= S_FIN;
        S_FIN:    state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = (state == S_RD_DIR) || (state == S_RD_TBL) ||
                (state == S_WB_DIR) || (state == S_WB_TBL);
    mem_we    = (state == S_WB_DIR) || (state == S_WB_TBL);
    mem_addr  = ((state == S_RD_DIR) || (state == S_WB_DIR)) ?
                dir_entry_addr(base_q, lin_q[31:22]) :
                tbl_entry_addr(pde_q[31:12], lin_q[21:12]);
    mem_wdata = (state == S_WB_DIR) ? dir_new : tbl_new;
    wb_orig   = (state == S_WB_DIR) ? pde_q : pte_q;
  end

  assign busy       = (state != S_IDLE);
  assign done       = (state == S_FIN);
  assign fault_code = fault_q;
  assign phys_addr  = pa_q;

  // R10: request held until acknowledged
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R11: completion is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !mem_req);

  // R9: write-back touches only the accessed/dirty bits and always changes the entry
  p_wb_flags_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> (((mem_wdata ^ wb_orig) & ~32'h0000_0060) == 32'd0) && (mem_wdata != wb_orig));

  // R8: no write on a faulting walk
  p_fault_no_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> fault_q == FLT_NONE);

  // R7: small pages stay below 4 GB
  p_small_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault_code == 2'd0 && !dir_is_large |-> phys_addr[PA_W-1:32] == '0);

  // R6: result fits the configured width
  p_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault_code == 2'd0 |-> (phys_addr >> width_q) == '0);

  // R4: narrow mode never sets bits above 35
  p_narrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault_code == 2'd0 && !wide_q |-> phys_addr[PA_W-1:36] == '0);
endmodule

// File: tb/tb_page_walker.sv
module tb_page_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] lin_addr = '0;
  logic [31:0] dir_base = '0;
  logic        large_en = 1'b0;
  logic        wide_mode = 1'b0;
  logic [5:0]  phys_width = 6'd36;
  logic        is_write = 1'b0;
  logic        busy, done, mem_req, mem_we;
  logic [1:0]  fault_code;
  logic [39:0] phys_addr;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  page_walker #(.PA_W(40)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .lin_addr(lin_addr),
    .dir_base(dir_base), .large_en(large_en), .wide_mode(wide_mode),
    .phys_width(phys_width), .is_write(is_write), .busy(busy), .done(done),
    .fault_code(fault_code), .phys_addr(phys_addr), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  always #2 clk = ~clk;  // 250 MHz

  typedef struct { bit we; logic [31:0] addr; logic [31:0] data; } op_t;
  op_t          exp_q[$];
  logic [31:0]  mem [int unsigned];
  int           n_chk = 0, n_err = 0, cyc = 0;
  int           lat_seq = 0, wait_cnt = 0;
  bit           in_txn = 0;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] expv);
    n_chk++;
    if (got !== expv) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, expv);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'd0;
  endfunction

  // behavioural reference: predicts memory traffic and the result
  task automatic model(input logic [31:0] lin, input logic [31:0] base, input bit pse,
                       input bit wide, input int width, input bit wr,
                       output logic [1:0] f, output logic [39:0] pa);
    logic [31:0] pa_d, pde, pte, pte_a;
    longint unsigned hi, big, rsv;
    f = 2'd0; pa = '0;
    pa_d = base + (lin >> 22) * 4;
    exp_q.push_back('{0, pa_d, 32'd0});
    pde = rd(pa_d);
    if (pde[0] == 1'b0) begin f = 2'd1; return; end
    if (pse && pde[7]) begin
      hi  = wide ? ((pde >> 13) & 32'hFF) : ((pde >> 13) & 32'hF);
      rsv = wide ? ((pde >> 21) & 1) : ((pde >> 17) & 32'h1F);
      big = (hi << 32) | (pde & 32'hFFC0_0000) | (lin & 32'h003F_FFFF);
      if ((big >> width) != 0) rsv = 1;
      if (rsv != 0) begin f = 2'd3; return; end
      pa = big[39:0];
      if ((pde | 32'h20 | (wr ? 32'h40 : 0)) != pde)
        exp_q.push_back('{1, pa_d, pde | 32'h20 | (wr ? 32'h40 : 0)});
    end else begin
      pte_a = (pde & 32'hFFFF_F000) + ((lin >> 12) & 32'h3FF) * 4;
      exp_q.push_back('{0, pte_a, 32'd0});
      pte = rd(pte_a);
      if (pte[0] == 1'b0) begin f = 2'd2; return; end
      pa = {8'h00, (pte & 32'hFFFF_F000) | (lin & 32'hFFF)};
      if ((pde | 32'h20) != pde) exp_q.push_back('{1, pa_d, pde | 32'h20});
      if ((pte | 32'h20 | (wr ? 32'h40 : 0)) != pte)
        exp_q.push_back('{1, pte_a, pte | 32'h20 | (wr ? 32'h40 : 0)});
    end
  endtask

  // memory responder with varying acknowledge delay; checks each transfer
  always @(negedge clk) begin
    mem_ack = 1'b0;
    if (rst_n && mem_req) begin
      if (!in_txn) begin in_txn = 1; wait_cnt = lat_seq % 3; lat_seq++; end
      if (wait_cnt == 0) begin
        in_txn = 0;
        mem_ack = 1'b1;
        if (exp_q.size() == 0) begin
          chk("R9 unexpected op", {31'd0, mem_we, mem_addr}, 64'hFFFF_FFFF_FFFF_FFFF);
        end else begin
          op_t e;
          e = exp_q.pop_front();
          if (e.we) chk("R9 write", {mem_we, mem_addr, mem_wdata}, {e.we, e.addr, e.data});
          else      chk("R2 read",  {31'd0, mem_we, mem_addr}, {31'd0, e.we, e.addr});
        end
        if (mem_we) mem[mem_addr] = mem_wdata;
        else mem_rdata = rd(mem_addr);
      end else wait_cnt--;
    end
  end

  task automatic walk(input string tag, input logic [31:0] lin, input bit pse,
                      input bit wide, input int width, input bit wr, input bit poke);
    logic [1:0] fe; logic [39:0] pe; int t;
    @(negedge clk);
    model(lin, 32'h0010_0000, pse, wide, width, wr, fe, pe);
    lin_addr = lin; dir_base = 32'h0010_0000; large_en = pse; wide_mode = wide;
    phys_width = 6'(width); is_write = wr; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin  // R11: start while busy must be ignored
      lin_addr = 32'hDEAD_B000; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    t = 0;
    while (!done && t < 300) begin @(negedge clk); t++; end
    chk({tag, " result"}, {22'd0, fault_code, phys_addr}, {22'd0, fe, pe});
    chk(fe != 0 ? "R8 pending ops" : "R9 pending ops", 64'(exp_q.size()), 64'd0);
    exp_q.delete();
    @(negedge clk);
    chk("R11 done pulse", {63'd0, done}, 64'd0);
    if (poke) begin
      repeat (4) @(negedge clk);
      chk("R11 no second walk", {62'd0, busy, mem_req}, 64'd0);
    end
  endtask

  initial begin
    // small page tables
    mem[32'h0010_0004] = 32'h0020_0001; mem[32'h0020_000C] = 32'h1234_5003;
    mem[32'h0010_0200] = 32'h0030_0081; mem[32'h0030_0014] = 32'h0ABC_D001;
    mem[32'h0010_0280] = 32'h0050_0001; mem[32'h0050_0004] = 32'h0000_0000;
    mem[32'h0010_0300] = 32'h0060_0001; mem[32'h0060_0008] = 32'h0111_1001;
    // large entries
    mem[32'h0010_00C0] = 32'hAB80_0000 | (32'h9 << 13) | 32'h81;
    mem[32'h0010_0100] = 32'h7FC0_0000 | (32'hA5 << 13) | 32'h81;
    mem[32'h0010_0140] = 32'h0040_0000 | (32'h10 << 13) | 32'h81;
    mem[32'h0010_0150] = 32'h0080_0000 | (32'h08 << 13) | 32'hA1;
    mem[32'h0010_0180] = 32'h0080_0000 | (32'h1 << 17) | 32'h81;
    mem[32'h0010_01C0] = 32'h00C0_0000 | (32'h1 << 21) | 32'h81;

    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {61'd0, mem_req, done, busy}, 64'd0);
    rst_n = 1'b1;

    walk("R7 small read",       32'h0040_3123, 1, 0, 36, 0, 0);
    walk("R9 small write",      32'h0040_3123, 1, 0, 36, 1, 0);
    walk("R9 clean repeat",     32'h0040_3123, 1, 0, 36, 1, 0);
    walk("R4 large narrow",     32'h0C12_3456, 1, 0, 36, 0, 0);
    walk("R5 large wide",       32'h1000_0ABC, 1, 1, 40, 1, 0);
    walk("R6 above width",      32'h1400_0000, 1, 1, 36, 0, 0);
    walk("R6 within width",     32'h1400_0000, 1, 1, 40, 0, 0);
    walk("R6 top bit at 35",    32'h1500_0777, 1, 1, 36, 1, 0);
    walk("R4 bit17 reserved",   32'h1800_0000, 1, 0, 36, 0, 0);
    walk("R5 bit17 as address", 32'h1800_0000, 1, 1, 40, 0, 0);
    walk("R5 bit21 reserved",   32'h1C00_0000, 1, 1, 40, 0, 0);
    walk("R3 size bit ignored", 32'h2000_5ABC, 0, 0, 36, 0, 0);
    walk("R3 size bit honoured",32'h2000_5ABC, 1, 0, 36, 0, 0);
    walk("R8 dir absent",       32'h2400_0000, 1, 0, 36, 1, 0);
    walk("R8 table absent",     32'h2800_1000, 1, 0, 36, 1, 0);
    chk("R8 dir entry untouched", {32'd0, rd(32'h0010_0280)}, {32'd0, 32'h0050_0001});
    walk("R11 start while busy",32'h3000_2000, 1, 0, 36, 1, 1);
    walk("R10 stalled walk",    32'h3000_2000, 1, 0, 36, 0, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_err++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
      end
    end
  end
endmodule